// File: doc/BRIEF.md
# Video Readback Fetch Address Generator with Line Repeat

This block produces the memory read addresses that fetch a stored source picture, one beat at a time, into an outbound FIFO. A separate bus master and FIFO do the actual transfer. Once the channel is enabled, the block waits for the next begin-of-field marker. It then starts at the base address of that field and walks the picture. The walk is set by a bytes-per-line count, a line count and a line pitch.

A downstream scaler can only scale horizontally, so vertical upscaling is done here. A 2-bit ratio makes the block fetch every source line up to four times before it moves to the next line. Requests stop while the FIFO reports full and pick up again at the next address, so no bytes are lost. After the last beat of the last repeat of the last line, the block flags completion. It then ignores field starts until it sees end-of-window. Only after that does the next begin-of-field start a new frame.

Top module: `line_repeat_fetch`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `req_valid`, `done` and `busy` are 0.
- R2: From idle, a fetch starts only at a clock edge that sees `bof` and `enable` both high. At that edge `field_odd` picks the base address (1 selects `base_odd`, 0 selects `base_even`). `busy` rises after that edge, and the first request can appear one edge later.
- R3: A line is fetched as `line_bytes`/4 consecutive 4-byte beats, with addresses stepping by 4 from the line start. `line_bytes` must be a nonzero multiple of 4.
- R4: `vratio` sets how often each line is fetched. 00 means once, 01 twice, 10 three times and 11 four times. Every repeat before the last one re-reads the same line start.
- R5: After the final repeat of a line, the line start moves forward by `pitch`.
- R6: A frame covers `line_count` lines (nonzero). `done` is a one-cycle pulse in the same cycle as the frame's last request.
- R7: If `fifo_full` is high at an edge, there is no request in the following cycle. The next request carries the next address in sequence, so none is skipped.
- R8: After `done`, no request is made and `bof` is ignored until `eow` is seen at an edge. After that, a `bof` starts a new frame.
- R9: If `enable` is low at an edge, the frame is abandoned. `req_valid` and `busy` are 0 in the next cycle.
- R10: The base, pitch, size and ratio inputs are captured at the start edge. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable; low abandons any frame |
| bof | input | 1 | Begin-of-field marker |
| eow | input | 1 | End-of-window marker |
| field_odd | input | 1 | Field type at `bof`: 1 odd, 0 even |
| base_odd | input | AW | Start address for odd fields |
| base_even | input | AW | Start address for even fields |
| pitch | input | AW | Address distance between source lines |
| line_bytes | input | BW | Bytes per source line |
| line_count | input | LW | Source lines per frame |
| vratio | input | 2 | Line repeat ratio (repeats minus one) |
| fifo_full | input | 1 | Outbound FIFO full; holds requests back |
| req_valid | output | 1 | A read request is presented this cycle |
| req_addr | output | AW | Byte address of the requested beat |
| busy | output | 1 | Frame fetch in progress |
| done | output | 1 | Pulse with the frame's final request |

## Verification
Frames are fetched with each ratio of one, two and four repeats. The odd and even base addresses are both used, along with different line widths and pitches. This separates a repeat count that is off by one from a pitch step taken on the wrong repeat. One frame runs with an irregular full pattern on the FIFO, which shows whether a stalled beat is dropped or sent twice. Further runs put `bof` in the post-frame wait, pull `enable` mid-frame and change the size inputs mid-frame. These show that the eow gate, the abort and the capture-at-start behaviour hold.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } lrf_state_e;
endpackage

// File: rtl/lrf_position.sv
// Tracks byte offset in the line, repeat number and line index.
module lrf_position #(
  parameter int BW   = 12,
  parameter int LW   = 10,
  parameter int BEAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [BW-1:0] line_bytes,
  input  logic [LW-1:0] line_count,
  input  logic [1:0]    ratio,
  output logic [BW-1:0] byte_off,
  output logic          line_adv,
  output logic          frame_end
);
  localparam logic [BW:0] BEAT_W = (BW+1)'(BEAT);

  logic [BW-1:0] lb_q;
  logic [LW-1:0] lc_q;
  logic [LW-1:0] line_idx;
  logic [1:0]    ratio_q;
  logic [1:0]    rep_cnt;
  logic          last_beat, last_rep, last_line;

  assign last_beat = ({1'b0, byte_off} + BEAT_W) == {1'b0, lb_q};
  assign last_rep  = (rep_cnt == ratio_q);
  assign last_line = ({1'b0, line_idx} + 1'b1) == {1'b0, lc_q};
  assign line_adv  = step && last_beat && last_rep;
  assign frame_end = last_beat && last_rep && last_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_q     <= '0;
      lc_q     <= '0;
      ratio_q  <= '0;
      byte_off <= '0;
      rep_cnt  <= '0;
      line_idx <= '0;
    end else if (load) begin
      lb_q     <= line_bytes;
      lc_q     <= line_count;
      ratio_q  <= ratio;
      byte_off <= '0;
      rep_cnt  <= '0;
      line_idx <= '0;
    end else if (step) begin
      if (last_beat) begin
        byte_off <= '0;
        if (last_rep) begin
          rep_cnt  <= '0;
          line_idx <= line_idx + 1'b1;
        end else begin
          rep_cnt <= rep_cnt + 1'b1;
        end
      end else begin
        byte_off <= byte_off + BW'(BEAT);
      end
    end
  end
endmodule

// File: rtl/lrf_addr.sv
// Holds the current line start and forms the registered request address.
module lrf_addr #(
  parameter int AW = 32,
  parameter int BW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic [AW-1:0] pitch,
  input  logic          line_adv,
  input  logic          issue,
  input  logic [BW-1:0] byte_off,
  output logic [AW-1:0] req_addr
);
  logic [AW-1:0] line_base;
  logic [AW-1:0] pitch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_base <= '0;
      pitch_q   <= '0;
      req_addr  <= '0;
    end else begin
      if (load) begin
        line_base <= load_base;
        pitch_q   <= pitch;
      end else if (line_adv) begin
        line_base <= line_base + pitch_q;
      end
      if (issue) req_addr <= line_base + AW'(byte_off);
    end
  end
endmodule

// File: rtl/line_repeat_fetch.sv
module line_repeat_fetch #(
  parameter int AW   = 32,
  parameter int BW   = 12,
  parameter int LW   = 10,
  parameter int BEAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          bof,
  input  logic          eow,
  input  logic          field_odd,
  input  logic [AW-1:0] base_odd,
  input  logic [AW-1:0] base_even,
  input  logic [AW-1:0] pitch,
  input  logic [BW-1:0] line_bytes,
  input  logic [LW-1:0] line_count,
  input  logic [1:0]    vratio,
  input  logic          fifo_full,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done
);
  import lrf_pkg::*;

  lrf_state_e    state, state_n;
  logic          load, issue, line_adv, frame_end;
  logic [BW-1:0] byte_off;

  assign load  = (state == ST_IDLE) && enable && bof;
  assign issue = (state == ST_FETCH) && enable && !fifo_full;

  always_comb begin
    state_n = state;
    if (!enable) begin
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (bof) state_n = ST_FETCH;
        ST_FETCH: if (issue && frame_end) state_n = ST_DRAIN;
        ST_DRAIN: if (eow) state_n = ST_IDLE;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_valid <= 1'b0;
      done      <= 1'b0;
      busy      <= 1'b0;
    end else begin
      state     <= state_n;
      req_valid <= issue;
      done      <= issue && frame_end;
      busy      <= (state_n == ST_FETCH);
    end
  end

  lrf_position #(.BW(BW), .LW(LW), .BEAT(BEAT)) i_pos (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .step       (issue),
    .line_bytes (line_bytes),
    .line_count (line_count),
    .ratio      (vratio),
    .byte_off   (byte_off),
    .line_adv   (line_adv),
    .frame_end  (frame_end)
  );

  lrf_addr #(.AW(AW), .BW(BW)) i_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_base (field_odd ? base_odd : base_even),
    .pitch     (pitch),
    .line_adv  (line_adv),
    .issue     (issue),
    .byte_off  (byte_off),
    .req_addr  (req_addr)
  );
endmodule

// File: rtl/lrf_checker.sv
module lrf_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic bof,
  input logic eow,
  input logic fifo_full,
  input logic req_valid,
  input logic busy,
  input logic done
);
  // R2: fetch only begins after an enabled bof
  a_r2_start_on_bof: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(bof) && $past(enable)));

  // R6: done accompanies a request
  a_r6_done_with_req: assert property (@(posedge clk) disable iff (rst)
    done |-> req_valid);

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a full FIFO holds back the next request
  a_r7_full_stall: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> !req_valid);

  // R8: nothing follows the final request until a new start
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && !eow) |=> (!req_valid && !busy));

  // R9: enable low abandons the frame
  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!req_valid && !busy));
endmodule

bind line_repeat_fetch lrf_checker i_lrf_checker (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .bof       (bof),
  .eow       (eow),
  .fifo_full (fifo_full),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_line_repeat_fetch.sv
`timescale 1ns/1ps
module test_line_repeat_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, bof = 1'b0, eow = 1'b0, field_odd = 1'b0;
  logic [31:0] base_odd = '0, base_even = '0, pitch = '0;
  logic [11:0] line_bytes = '0;
  logic [9:0]  line_count = '0;
  logic [1:0]  vratio = '0;
  logic        fifo_full = 1'b0;
  logic        req_valid, busy, done;
  logic [31:0] req_addr;

  always #4 clk = ~clk;

  line_repeat_fetch i_line_repeat_fetch (
    .clk(clk), .rst(rst), .enable(enable), .bof(bof), .eow(eow),
    .field_odd(field_odd), .base_odd(base_odd), .base_even(base_even),
    .pitch(pitch), .line_bytes(line_bytes), .line_count(line_count),
    .vratio(vratio), .fifo_full(fifo_full), .req_valid(req_valid),
    .req_addr(req_addr), .busy(busy), .done(done)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_req = "R3";

  // reference model: address list built from the requirements
  logic [31:0] addr_q[$];
  int          m_st = 0;   // 0 idle, 1 fetching, 2 waiting for eow
  logic        exp_valid = 0, exp_done = 0, exp_busy = 0;
  logic [31:0] exp_addr = '0;
  int          n_req = 0, n_done = 0;

  always @(posedge clk) begin
    exp_valid = 0;
    exp_done  = 0;
    if (rst) begin
      m_st = 0;
      addr_q.delete();
    end else if (!enable) begin
      m_st = 0;
      addr_q.delete();
    end else begin
      case (m_st)
        0: if (bof) begin
             logic [31:0] b;
             b = field_odd ? base_odd : base_even;
             addr_q.delete();
             for (int l = 0; l < int'(line_count); l++)
               for (int r = 0; r <= int'(vratio); r++)
                 for (int k = 0; k < int'(line_bytes) / 4; k++)
                   addr_q.push_back(b + 32'(l) * pitch + 32'(k * 4));
             m_st = 1;
           end
        1: if (!fifo_full) begin
             exp_valid = 1;
             exp_addr  = addr_q.pop_front();
             if (addr_q.size() == 0) begin
               exp_done = 1;
               m_st = 2;
             end
           end
        default: if (eow) m_st = 0;
      endcase
    end
    exp_busy = (m_st == 1);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(req_valid === exp_valid, cur_req, "req_valid", req_valid, exp_valid);
      if (exp_valid)
        check(req_addr === exp_addr, cur_req, "req_addr", req_addr, exp_addr);
      check(done === exp_done, "R6", "done", done, exp_done);
      check(busy === exp_busy, cur_req, "busy", busy, exp_busy);
      if (req_valid) n_req++;
      if (done) n_done++;
    end
  end

  // irregular FIFO-full pattern for R7
  bit stall_en = 0;
  int stall_cyc = 0;
  always @(negedge clk) begin
    if (stall_en) begin
      stall_cyc++;
      fifo_full = (stall_cyc % 5 == 1) || (stall_cyc % 7 == 3) || (stall_cyc % 11 == 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_bof();
    @(negedge clk); bof = 1;
    @(negedge clk); bof = 0;
  endtask

  task automatic pulse_eow();
    @(negedge clk); eow = 1;
    @(negedge clk); eow = 0;
  endtask

  task automatic wait_drain();
    while (m_st != 2) @(negedge clk);
    cycles(2);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "WATCHDOG", "timeout", 0, 1);
    summary();
  end

  initial begin
    int expn;
    cycles(4);
    check(req_valid === 0 && done === 0 && busy === 0, "R1", "in reset", req_valid, 0);
    rst = 0;
    @(negedge clk);
    check(req_valid === 0 && done === 0 && busy === 0, "R1", "after reset", busy, 0);

    // R2: bof without enable, then enable without bof
    cur_req = "R2";
    base_odd = 32'h1000; base_even = 32'h8000; pitch = 32'h100;
    line_bytes = 16; line_count = 3; vratio = 0;
    pulse_bof(); cycles(4);
    check(busy === 0, "R2", "bof while disabled", busy, 0);
    enable = 1; cycles(5);
    check(busy === 0, "R2", "enabled no bof", busy, 0);

    // R3/R5: single read per line, odd field
    cur_req = "R3"; field_odd = 1; n_req = 0; n_done = 0;
    pulse_bof(); wait_drain();
    check(n_req == 12, "R3", "beats odd frame", n_req, 12);
    check(n_done == 1, "R6", "done count", n_done, 1);
    pulse_eow();

    // R4/R10: four repeats, even field, inputs changed mid-frame
    cur_req = "R4"; field_odd = 0; vratio = 3; line_bytes = 8; line_count = 2; pitch = 32'h40;
    n_req = 0; n_done = 0;
    pulse_bof(); cycles(3);
    vratio = 1; line_bytes = 4; pitch = 32'h999; base_even = 32'h0;
    cur_req = "R10";
    wait_drain();
    check(n_req == 16, "R4", "repeat beats", n_req, 16);
    check(n_req == 16, "R10", "latched sizes", n_req, 16);
    pulse_eow();

    // R7: two repeats under FIFO back-pressure
    cur_req = "R7"; base_odd = 32'h2_0000; field_odd = 1; vratio = 1;
    line_bytes = 12; line_count = 4; pitch = 32'h200;
    n_req = 0; n_done = 0;
    pulse_bof(); stall_en = 1; wait_drain(); stall_en = 0; fifo_full = 0;
    check(n_req == 24, "R7", "beats with stalls", n_req, 24);
    check(n_req == 24, "R5", "pitch frame beats", n_req, 24);

    // R8: bof ignored before eow
    cur_req = "R8"; n_req = 0;
    pulse_bof(); cycles(6);
    check(n_req == 0 && busy === 0, "R8", "reqs before eow", n_req, 0);
    pulse_eow(); n_done = 0;
    pulse_bof(); wait_drain();
    expn = 24;
    check(n_req == expn, "R8", "restart after eow", n_req, expn);
    check(n_done == 1, "R6", "done after restart", n_done, 1);
    pulse_eow();

    // R9: abort mid-frame
    cur_req = "R9"; line_count = 20; vratio = 2; line_bytes = 16;
    pulse_bof(); cycles(10);
    enable = 0; cycles(2);
    n_req = 0;
    cycles(5);
    check(busy === 0 && n_req == 0, "R9", "after abort", n_req, 0);
    cycles(2);
    summary();
  end
endmodule